// File: doc/BRIEF.md
# Microcode ALU and Shifter Stage

This block is the arithmetic stage of a 16-bit microcoded processor. Each microcycle it takes the resolved bus value and the T register, and forms a result from a 4-bit function code. The bus value arrives already resolved: every source has been ANDed into an all-ones starting value before it reaches the block. On a load strobe the result updates L, and a per-code choice updates T from either the result or the raw bus. L also latches a carry flag.

A shifter reads the current L under control of the F1 field. The F2 field selects one branch condition. That condition is presented as a small word, which the sequencer ORs into its next microaddress.

Top module: `mcode_alu`

## Requirements
- R1: After reset, L, T and the latched carry are all 0.
- R2: Logic function codes (octal) give these results: 0 = bus, 1 = T, 2 = bus OR T, 3 and 14 = bus AND T, 4 = bus XOR T, 15 = bus AND NOT T.
- R3: Arithmetic codes give these results modulo 2^16: 5 = bus+1, 6 = bus-1, 7 = bus+T, 10 = bus-T, 11 = bus-T-1, 12 = bus+T+1.
- R4: Code 13 gives bus+1 when skip is 1 and gives the bus unchanged when skip is 0.
- R5: Codes 16 and 17 give a result of 0 and a carry of 0.
- R6: When load_t is 1, T takes the ALU result for codes 0, 2, 5, 6, 12, 13 and 14, and takes the bus value for every other code.
- R7: When load_l is 1, L takes the ALU result. The carry latches the 17th sum bit for codes 5 to 13 and 16 to 17, and latches 0 for all other codes. For subtraction a carry of 1 means no borrow.
- R8: With load_l and load_t at 0, L, T and the carry hold their values whatever the other inputs do.
- R9: The shifter output depends on F1: 4 gives L shifted left by one, 5 gives L shifted right by one with a zero fill, 6 gives L with its bytes swapped, and any other code gives L unchanged.
- R10: br_or (NW = 10 bits) depends on F2: 1 gives bit0 = (bus == 0), 2 gives bit0 = shifter bit 15, 3 gives bit0 = (shifter == 0), 4 gives bus[9:0], 5 gives bit0 = NOT latched carry. Any other code gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_in | input | 16 | Resolved wired-AND bus value |
| aluf | input | 4 | ALU function code |
| f1 | input | 4 | F1 field, shifter control |
| f2 | input | 4 | F2 field, branch select |
| load_l | input | 1 | Load L and the carry at the clock edge |
| load_t | input | 1 | Load T at the clock edge |
| skip | input | 1 | Skip input for code 13 |
| alu_o | output | 16 | ALU result |
| sh_o | output | 16 | Shifter result |
| l_q | output | 16 | L register |
| t_q | output | 16 | T register |
| cy_q | output | 1 | Latched carry |
| br_or | output | 10 | Branch bits for the next address |

## Verification
The bench builds the block with its defaults: W = 16 and NW = 10. With these values the carry boundaries are reachable with directed values: 0xFFFF + 1, 0 - 1, and equal operands in subtraction. The F2 bus branch also exposes exactly bits 9:0, so a bus value with bit 10 set shows whether the mask is right. The bench writes a 16-bit L with distinct bytes (0x81C3), so every shift direction and the byte swap give a different pattern.

// File: rtl/mcode_alu.sv
module mcode_alu #(
  parameter int W  = 16,
  parameter int NW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  bus_in,
  input  logic [3:0]    aluf,
  input  logic [3:0]    f1,
  input  logic [3:0]    f2,
  input  logic          load_l,
  input  logic          load_t,
  input  logic          skip,
  output logic [W-1:0]  alu_o,
  output logic [W-1:0]  sh_o,
  output logic [W-1:0]  l_q,
  output logic [W-1:0]  t_q,
  output logic          cy_q,
  output logic [NW-1:0] br_or
);
  localparam int HB = W / 2;

  logic [W-1:0] addb, res;
  logic [W:0]   sum;
  logic         cin, arith, t_from_alu, cy_d;

  assign sum = {1'b0, bus_in} + {1'b0, addb} + {{W{1'b0}}, cin};

  always_comb begin
    addb = '0; cin = 1'b0; arith = 1'b0; t_from_alu = 1'b0; res = '0;
    case (aluf)
      4'o00: begin res = bus_in;          t_from_alu = 1'b1; end
      4'o01:       res = t_q;
      4'o02: begin res = bus_in | t_q;    t_from_alu = 1'b1; end
      4'o03:       res = bus_in & t_q;
      4'o04:       res = bus_in ^ t_q;
      4'o05: begin cin = 1'b1;  arith = 1'b1; t_from_alu = 1'b1; end
      4'o06: begin addb = '1;   arith = 1'b1; t_from_alu = 1'b1; end
      4'o07: begin addb = t_q;  arith = 1'b1; end
      4'o10: begin addb = ~t_q; cin = 1'b1; arith = 1'b1; end
      4'o11: begin addb = ~t_q; arith = 1'b1; end
      4'o12: begin addb = t_q;  cin = 1'b1; arith = 1'b1; t_from_alu = 1'b1; end
      4'o13: begin cin = skip;  arith = 1'b1; t_from_alu = 1'b1; end
      4'o14: begin res = bus_in & t_q;    t_from_alu = 1'b1; end
      4'o15:       res = bus_in & ~t_q;
      default: arith = 1'b1;
    endcase
  end

  wire zero_code = (aluf[3:1] == 3'b111);
  assign alu_o = (arith && !zero_code) ? sum[W-1:0] : res;
  assign cy_d  = arith && !zero_code && sum[W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_q <= '0; t_q <= '0; cy_q <= 1'b0;
    end else begin
      if (load_l) begin
        l_q  <= alu_o;
        cy_q <= cy_d;
      end
      if (load_t) t_q <= t_from_alu ? alu_o : bus_in;
    end
  end

  always_comb begin
    case (f1)
      4'd4:    sh_o = {l_q[W-2:0], 1'b0};
      4'd5:    sh_o = {1'b0, l_q[W-1:1]};
      4'd6:    sh_o = {l_q[HB-1:0], l_q[W-1:HB]};
      default: sh_o = l_q;
    endcase
  end

  always_comb begin
    br_or = '0;
    case (f2)
      4'd1: br_or[0] = (bus_in == '0);
      4'd2: br_or[0] = sh_o[W-1];
      4'd3: br_or[0] = (sh_o == '0);
      4'd4: br_or = bus_in[NW-1:0];
      4'd5: br_or[0] = ~cy_q;
      default: br_or = '0;
    endcase
  end

  AST_L_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) !load_l |=> $stable(l_q));  // R8
  AST_T_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) !load_t |=> $stable(t_q));  // R8
  AST_CY_LOGIC: assert property (@(posedge clk) disable iff (!rst_n)
                  (load_l && (aluf <= 4'o04 || aluf == 4'o14 || aluf == 4'o15)) |=> !cy_q);      // R7
  AST_ZERO_OP:  assert property (@(posedge clk) disable iff (!rst_n)
                  (load_l && aluf[3:1] == 3'b111) |=> (l_q == '0 && !cy_q));                     // R5
  AST_T_BUS:    assert property (@(posedge clk) disable iff (!rst_n)
                  (load_t && aluf == 4'o01) |=> t_q == $past(bus_in));                           // R6
  AST_SH_FILL:  assert property (@(posedge clk) disable iff (!rst_n)
                  (f1 == 4'd5 |-> !sh_o[W-1]) and (f1 == 4'd4 |-> !sh_o[0]));                    // R9
endmodule

// File: tb/mcode_alu_tb_top.sv
module mcode_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_in = '0;
  logic [3:0]  aluf = '0, f1 = '0, f2 = '0;
  logic        load_l = 1'b0, load_t = 1'b0, skip = 1'b0;
  logic [15:0] alu_o, sh_o, l_q, t_q;
  logic        cy_q;
  logic [9:0]  br_or;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mcode_alu dut_i (.clk, .rst_n, .bus_in, .aluf, .f1, .f2, .load_l, .load_t, .skip,
                   .alu_o, .sh_o, .l_q, .t_q, .cy_q, .br_or);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // expected {carry,result} from the requirements
  function automatic logic [16:0] model(input logic [3:0] c, input int b, input int t, input bit s);
    int r; bit cy;
    cy = 0;
    case (c)
      4'o00: r = b;
      4'o01: r = t;
      4'o02: r = b | t;
      4'o03, 4'o14: r = b & t;
      4'o04: r = b ^ t;
      4'o05: begin r = b + 1; cy = (b == 65535); end
      4'o06: begin r = b - 1; cy = (b != 0); end
      4'o07: begin r = b + t; cy = (b + t > 65535); end
      4'o10: begin r = b - t; cy = (b >= t); end
      4'o11: begin r = b - t - 1; cy = (b > t); end
      4'o12: begin r = b + t + 1; cy = (b + t + 1 > 65535); end
      4'o13: begin r = b + int'(s); cy = (b + int'(s) > 65535); end
      4'o15: r = b & ~t;
      default: r = 0;
    endcase
    return {cy, r[15:0]};
  endfunction

  task automatic load_regs(input logic [15:0] lv, input logic [15:0] tv);
    aluf = 4'o00; bus_in = tv; load_t = 1; load_l = 0; step();
    bus_in = lv; load_t = 0; load_l = 1; step();
    load_l = 0;
  endtask

  task automatic t_reset();
    chk("R1 L", l_q, 0); chk("R1 T", t_q, 0); chk("R1 cy", cy_q, 0);
  endtask

  task automatic t_logic();
    load_regs(16'h1234, 16'hF0F0);
    foreach (aluf_list_l[i]) begin
      aluf = aluf_list_l[i]; bus_in = 16'h5A3C; #1;
      chk($sformatf("R2 code %o", aluf), alu_o, model(aluf, 'h5A3C, 'hF0F0, 0) & 17'hFFFF);
    end
  endtask
  logic [3:0] aluf_list_l [7] = '{4'o00, 4'o01, 4'o02, 4'o03, 4'o04, 4'o14, 4'o15};

  task automatic t_arith();
    logic [15:0] bv [3] = '{16'hFFFF, 16'h0000, 16'h8000};
    logic [15:0] tv [3] = '{16'h0001, 16'h0000, 16'h8000};
    for (int k = 0; k < 3; k++) begin
      load_regs(16'h0, tv[k]);
      for (int c = 5; c <= 10; c++) begin
        logic [16:0] e;
        aluf = (c <= 7) ? c[3:0] : 4'(c + 0);
        aluf = (c == 8) ? 4'o10 : (c == 9) ? 4'o11 : (c == 10) ? 4'o12 : c[3:0];
        bus_in = bv[k]; #1;
        e = model(aluf, bv[k], tv[k], 0);
        chk($sformatf("R3 code %o", aluf), alu_o, e[15:0]);
        load_l = 1; step(); load_l = 0;
        chk($sformatf("R7 carry code %o", aluf), cy_q, e[16]);
      end
    end
  endtask

  task automatic t_skip();
    aluf = 4'o13; bus_in = 16'h0041; skip = 1; #1; chk("R4 skip1", alu_o, 16'h0042);
    skip = 0; #1; chk("R4 skip0", alu_o, 16'h0041);
    bus_in = 16'hFFFF; skip = 1; load_l = 1; step(); load_l = 0;
    chk("R4 wrap", l_q, 0); chk("R7 skip carry", cy_q, 1);
    skip = 0;
  endtask

  task automatic t_zero();
    load_regs(16'h0, 16'hFFFF);
    aluf = 4'o05; bus_in = 16'hFFFF; load_l = 1; step();
    chk("R7 pre carry", cy_q, 1);
    aluf = 4'o16; bus_in = 16'h7777; #1; chk("R5 16", alu_o, 0);
    step(); chk("R5 carry", cy_q, 0); chk("R5 L", l_q, 0);
    aluf = 4'o17; #1; chk("R5 17", alu_o, 0);
    load_l = 0;
  endtask

  task automatic t_tsrc();
    for (int c = 0; c < 16; c++) begin
      logic [16:0] e; bit alu_src;
      load_regs(16'h0, 16'h0F0F);
      aluf = c[3:0]; bus_in = 16'h3333; skip = 1;
      e = model(aluf, 'h3333, 'h0F0F, 1);
      alu_src = (c == 0 || c == 2 || c == 5 || c == 6 || c == 10 || c == 11 || c == 12);
      load_t = 1; step(); load_t = 0;
      chk($sformatf("R6 code %o", c), t_q, alu_src ? e[15:0] : 16'h3333);
    end
    skip = 0;
  endtask

  task automatic t_logic_cy();
    aluf = 4'o05; bus_in = 16'hFFFF; load_l = 1; step();
    aluf = 4'o04; bus_in = 16'h1111; step(); load_l = 0;
    chk("R7 logic clears carry", cy_q, 0);
    chk("R7 L from alu", l_q, 16'h1111 ^ t_q);
  endtask

  task automatic t_hold();
    load_regs(16'hBEEF, 16'hCAFE);
    aluf = 4'o05; bus_in = 16'hFFFF; load_l = 1; step(); load_l = 0;
    aluf = 4'o04; bus_in = 16'h1234; step();
    chk("R8 L", l_q, 0); chk("R8 T", t_q, 16'hCAFE); chk("R8 cy", cy_q, 1);
  endtask

  task automatic t_shift();
    load_regs(16'h81C3, 16'h0);
    f1 = 4; #1; chk("R9 lsh", sh_o, 16'h0386);
    f1 = 5; #1; chk("R9 rsh", sh_o, 16'h40E1);
    f1 = 6; #1; chk("R9 swap", sh_o, 16'hC381);
    f1 = 7; #1; chk("R9 pass", sh_o, 16'h81C3);
    f1 = 0;
  endtask

  task automatic t_branch();
    load_regs(16'h8000, 16'h0);
    f2 = 1; bus_in = 16'h0; #1; chk("R10 bus0", br_or, 1);
    bus_in = 16'h0100; #1; chk("R10 bus nz", br_or, 0);
    f2 = 2; #1; chk("R10 sh neg", br_or, 1);
    f2 = 3; #1; chk("R10 sh nz", br_or, 0);
    f1 = 4; #1; chk("R10 sh zero", br_or, 1); f1 = 0;
    f2 = 4; bus_in = 16'hA7FF; #1; chk("R10 bus bits", br_or, 10'h3FF);
    aluf = 4'o04; load_l = 1; step(); load_l = 0;
    f2 = 5; #1; chk("R10 not carry", br_or, 1);
    aluf = 4'o05; bus_in = 16'hFFFF; load_l = 1; step(); load_l = 0;
    #1; chk("R10 carry set", br_or, 0);
    f2 = 7; #1; chk("R10 other", br_or, 0);
    f2 = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset(); t_logic(); t_arith(); t_skip(); t_zero(); t_tsrc();
    t_logic_cy(); t_hold(); t_shift(); t_branch();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule